// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block collects five peripheral interrupt request lines and converts every low-to-high transition on them into a sticky pending flag. A caller presents a new set of line levels together with a select mask in a single update cycle. Only the lines whose mask bit is set take the new level, and every other line keeps the level it had. The block stores the current level of each line so that it can recognise a rising edge. It does not latch a level that is merely held high.

Software reads the pending-flag register and an enable register through plain output ports, and writes either of them through one register write port. A master-enable input gates wake-up. When an edge sets a flag that was clear, that flag's enable bit is set, and the master enable is on, the block emits a one-cycle wake pulse. The pulse ends a halted CPU. Choosing a vector, resolving priority and acknowledging a flag from the core are left to other logic.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Only bits 4..0 of `req_level`, `req_mask` and `reg_wdata` are used, and bit i controls line or flag i. Bits 7..5 of these inputs have no effect on any output.
- R2: In a cycle with `req_valid` high, each line whose mask bit is 1 takes the new level and each line whose mask bit is 0 keeps its level. With `req_valid` low, no line changes. `line_lvl` shows the stored levels one cycle after the update.
- R3: A flag bit is set only when its stored line goes from 0 to 1 in an update. A line that is already 1 and is written 1 again does not set its flag.
- R4: A pulse that raises a line and lowers it again sets the flag exactly once. After software clears the flag, lowering the line again does not set it.
- R5: A flag stays set until software writes the flag register (`reg_wr`=1, `reg_sel`=0). That write loads the flags from `reg_wdata` bits 4..0.
- R6: When a flag write and a rising edge fall in the same cycle, the resulting flags are the written value ORed with the rising-edge bits.
- R7: A write with `reg_wr`=1 and `reg_sel`=1 loads the enable register from `reg_wdata` bits 4..0 and leaves the flags untouched.
- R8: `wake` is high for exactly the one cycle after an update cycle in which some rising edge hit a flag that was clear and whose enable bit was set, provided `ime` was high in that update cycle. In every other cycle `wake` is low.
- R9: A rising edge on a line whose flag is already set produces no wake pulse.
- R10: After reset, all line levels, flags and enables are zero and `wake` is low.
- R11: `flag_rd` and `en_rd` return the five register bits in bits 4..0 and ones in bits 7..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Applies a masked line update this cycle |
| req_level | input | 8 | New line levels, bits 4..0 used |
| req_mask | input | 8 | Line select mask, bits 4..0 used |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = flags, 1 = enables |
| reg_wdata | input | 8 | Register write data, bits 4..0 used |
| ime | input | 1 | Master enable for wake generation |
| line_lvl | output | 5 | Stored line levels |
| flag_rd | output | 8 | Pending flags, upper three bits read as ones |
| en_rd | output | 8 | Enable register, upper three bits read as ones |
| wake | output | 1 | One-cycle halt-wake pulse |

## Verification
The collision that matters is a software write to the flag register landing in the same cycle as a line update that produces rising edges. The write must not erase the edge, and the wake decision must use the flag state from before the write. The sweep walks every level and mask combination while flag writes, enable writes and master-enable changes are interleaved on a fixed rhythm. Many vectors therefore carry both a write and an edge. A model of the line, flag and enable state in the bench predicts every output after each vector, and directed sequences cover pulses, edges on already-set flags and the simultaneous clear-and-set case.

// File: rtl/irq_pkg.sv
package irq_pkg;

  parameter int unsigned IRQ_N = 5;

  typedef logic [IRQ_N-1:0] irq_vec_t;

  // New line state after a masked update
  function automatic irq_vec_t merge_masked(irq_vec_t cur, irq_vec_t val, irq_vec_t msk);
    return (cur & ~msk) | (val & msk);
  endfunction

  // Lines that go low-to-high under this update
  function automatic irq_vec_t rising_bits(irq_vec_t cur, irq_vec_t val, irq_vec_t msk);
    return val & msk & ~cur;
  endfunction

  // Flag register next value, software write first, edges always OR in
  function automatic irq_vec_t flag_next(irq_vec_t cur, irq_vec_t rise,
                                         logic we, irq_vec_t wd);
    return (we ? wd : cur) | rise;
  endfunction

endpackage

// File: rtl/irq_line_tracker.sv
module irq_line_tracker
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  irq_vec_t lvl,
  input  irq_vec_t msk,
  output irq_vec_t lines_q,
  output irq_vec_t rise
);

  irq_vec_t lines_d;

  always_comb begin
    lines_d = lines_q;
    rise    = '0;
    if (upd) begin
      lines_d = merge_masked(lines_q, lvl, msk);
      rise    = rising_bits(lines_q, lvl, msk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_d;
  end

  // R2
  masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(upd) |->
      ((lines_q & ~$past(msk)) == ($past(lines_q) & ~$past(msk))) &&
      ((lines_q & $past(msk)) == ($past(lvl) & $past(msk))));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(upd) |-> $stable(lines_q));

  // R3
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(rise) != '0) |-> (($past(lines_q) & $past(rise)) == '0)
      && ((lines_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t rise,
  input  logic     flag_we,
  input  logic     en_we,
  input  irq_vec_t wdata,
  output irq_vec_t flags_q,
  output irq_vec_t en_q,
  output irq_vec_t newly
);

  irq_vec_t flags_d;
  irq_vec_t en_d;

  always_comb begin
    flags_d = flag_next(flags_q, rise, flag_we, wdata);
    en_d    = en_we ? wdata : en_q;
    newly   = rise & ~flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
    end
  end

  // R5
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(flag_we) |-> (($past(flags_q) & ~flags_q) == '0));

  // R3
  set_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(flag_we) |-> ((flags_q & ~$past(flags_q) & ~$past(rise)) == '0));

  // R6
  write_or_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(flag_we) |-> flags_q == ($past(wdata) | $past(rise)));

  // R7
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(en_we) |-> $stable(en_q));

endmodule

// File: rtl/irq_wake_gen.sv
module irq_wake_gen
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t newly,
  input  irq_vec_t en,
  input  logic     ime,
  output logic     wake
);

  logic hit;

  always_comb hit = ime && ((newly & en) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= hit;
  end

  // R8
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(rst_n) && $past(ime) && (($past(newly) & $past(en)) != '0));

  // R8
  wake_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ime) && (($past(newly) & $past(en)) != '0) |-> wake);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [REG_W-1:0] req_level,
  input  logic [REG_W-1:0] req_mask,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             ime,
  output logic [IRQ_N-1:0] line_lvl,
  output logic [REG_W-1:0] flag_rd,
  output logic [REG_W-1:0] en_rd,
  output logic             wake
);

  localparam int unsigned PAD_W = REG_W - IRQ_N;
  localparam logic [PAD_W-1:0] PAD_ONES = '1;

  irq_vec_t lvl_lo, msk_lo, wd_lo;
  irq_vec_t lines_q, rise, flags_q, en_q, newly;
  logic     flag_we, en_we;
  logic     unused_hi;

  assign lvl_lo    = req_level[IRQ_N-1:0];
  assign msk_lo    = req_mask[IRQ_N-1:0];
  assign wd_lo     = reg_wdata[IRQ_N-1:0];
  assign unused_hi = ^{req_level[REG_W-1:IRQ_N], req_mask[REG_W-1:IRQ_N],
                       reg_wdata[REG_W-1:IRQ_N]};

  assign flag_we = reg_wr && !reg_sel;
  assign en_we   = reg_wr &&  reg_sel;

  irq_line_tracker u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (req_valid),
    .lvl     (lvl_lo),
    .msk     (msk_lo),
    .lines_q (lines_q),
    .rise    (rise)
  );

  irq_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .flag_we (flag_we),
    .en_we   (en_we),
    .wdata   (wd_lo),
    .flags_q (flags_q),
    .en_q    (en_q),
    .newly   (newly)
  );

  irq_wake_gen u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .newly (newly),
    .en    (en_q),
    .ime   (ime),
    .wake  (wake)
  );

  assign line_lvl = lines_q;
  assign flag_rd  = {PAD_ONES, flags_q};
  assign en_rd    = {PAD_ONES, en_q};

  // R9
  no_rewake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req_valid) && (($past(rise) & ~$past(flags_q)) == '0) |-> !wake);

endmodule

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_level = '0;
  logic [7:0] req_mask = '0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       ime = 1'b0;
  logic [4:0] line_lvl;
  logic [7:0] flag_rd;
  logic [7:0] en_rd;
  logic       wake;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [4:0] m_lines = '0, m_flags = '0, m_en = '0;

  always #4 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_mask(req_mask), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ime(ime), .line_lvl(line_lvl),
    .flag_rd(flag_rd), .en_rd(en_rd), .wake(wake)
  );

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      bad = 1'b1;
    end
  endtask

  task automatic check_all(string tag, logic exp_wake);
    bit bad = 1'b0;
    vectors++;
    cmp({tag, " R2 lines"}, {3'b0, line_lvl}, {3'b0, m_lines}, bad);
    cmp({tag, " R3/R5/R6 flags R11"}, flag_rd, {3'b111, m_flags}, bad);
    cmp({tag, " R7 enables R11"}, en_rd, {3'b111, m_en}, bad);
    cmp({tag, " R8/R9 wake"}, {7'b0, wake}, {7'b0, exp_wake}, bad);
    if (bad) fails++;
  endtask

  task automatic apply(string tag, logic v, logic [7:0] lv, logic [7:0] mk,
                       logic w, logic s, logic [7:0] wd, logic ie);
    logic [4:0] nl, nf, ne;
    logic ew = 1'b0;
    nl = m_lines; nf = m_flags; ne = m_en;
    for (int b = 0; b < 5; b++) begin
      logic up;
      up = v && mk[b] && lv[b] && !m_lines[b];
      if (v && mk[b]) nl[b] = lv[b];
      if (w && !s) nf[b] = wd[b];
      if (up) nf[b] = 1'b1;
      if (w && s) ne[b] = wd[b];
      if (up && !m_flags[b] && m_en[b] && ie) ew = 1'b1;
    end
    req_valid = v; req_level = lv; req_mask = mk;
    reg_wr = w; reg_sel = s; reg_wdata = wd; ime = ie;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    m_lines = nl; m_flags = nf; m_en = ne;
    check_all(tag, ew);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      $display("FAIL watchdog: actual hung expected finished");
      fails++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state, R11 read-back padding
    check_all("R10 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 after release", 1'b0);

    // R7 enable all, then R1 upper bits ignored
    apply("R7 en write", 0, 8'h00, 8'h00, 1, 1, 8'hFF, 1);
    apply("R1 upper only", 1, 8'hE0, 8'hE0, 0, 0, 8'h00, 1);
    apply("R1 flag write hi bits", 0, 8'h00, 8'h00, 1, 0, 8'hE0, 1);

    // R4 pulse on line 2: up sets and wakes, down does nothing
    apply("R4 pulse up", 1, 8'h04, 8'h04, 0, 0, 0, 1);
    apply("R4 pulse down", 1, 8'h00, 8'h04, 0, 0, 0, 1);
    apply("R4 idle", 0, 8'h00, 8'h00, 0, 0, 0, 1);
    apply("R4 clear", 0, 8'h00, 8'h00, 1, 0, 8'h00, 1);
    apply("R4 lower again", 1, 8'h00, 8'h04, 0, 0, 0, 1);

    // R3 held-high line does not set again
    apply("R3 raise l0", 1, 8'h01, 8'h01, 0, 0, 0, 0);
    apply("R3 clear", 0, 0, 0, 1, 0, 8'h00, 1);
    apply("R3 hold high", 1, 8'h01, 8'h01, 0, 0, 0, 1);

    // R9 edge on already-set flag: no wake
    apply("R9 raise l1", 1, 8'h02, 8'h02, 0, 0, 0, 0);
    apply("R9 drop l1", 1, 8'h00, 8'h02, 0, 0, 0, 1);
    apply("R9 re-raise l1", 1, 8'h02, 8'h02, 0, 0, 0, 1);

    // R6 clear and edge in the same cycle
    apply("R6 clear+edge", 1, 8'h08, 8'h08, 1, 0, 8'h10, 1);
    apply("R8 disabled line", 0, 0, 0, 1, 1, 8'h00, 1);
    apply("R8 edge no enable", 1, 8'h1F, 8'h1F, 0, 0, 0, 1);

    // Sweep over all level and mask pairs with interleaved writes
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 1024; v++) begin
        logic [7:0] lv, mk, wd;
        logic w, s;
        lv = {p[2:0] ^ 3'b101, v[4:0]};
        mk = {p[2:0], v[9:5]};
        w  = (v % 6 == 0) || (v % 11 == 0);
        s  = (v % 6 != 0);
        wd = 8'((v * 13 + p * 7) & 8'hFF);
        apply("R2 sweep", (v % 5) != 4, lv, mk, w, s, wd, p[0] ^ v[3]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule